// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is an asynchronous serial transmitter and receiver behind a small register bus. The bus has four addresses: a shared data address, a mode register, a status register and a baud divisor. A write to the data address loads the transmit holding register and starts a frame on `txd`. A read from the data address returns the receive buffer. There is no path that reads back the transmit register.

Each frame has a low start bit, then the data LSB first, then an optional parity bit, then one or two high stop bits. The line idles high. The baud divisor sets a 16x sampling tick. The receiver confirms the start bit at its middle and samples each later bit at its centre. A received character moves into the receive buffer in one step, at the stop bit. Parity errors, framing errors and overruns are held as sticky flags in the status register, and a status read clears them.

The bus is a plain register interface with one-cycle strobes. It has no back-pressure. A write is either taken in the cycle it is strobed or dropped, as R6 and R14 define. Read data is combinational from the address while `bus_rd` is high. The read side effects take place at the clock edge that ends the strobe.

Top module: `uart_regport`

## Requirements
- R1: After reset, a read of the data address (0) returns 0xFF. A read of the status address (2) returns 0x00. A read of the mode address (1) returns 0x00. `txd` is high.
- R2: When transmit is enabled (mode bit 0) and a frame is not in progress, a write to address 0 starts a frame. The frame is a low start bit, then the data bits LSB first, then the stop bits, which are high. Mode bit 2 = 1 selects 8 data bits.
- R3: With mode bit 2 = 0, exactly 7 data bits (bits 0 to 6) are sent, and bit 7 of the written value has no effect on the line.
- R4: Mode bits [4:3] select the parity bit that follows the data. The codes are 0 = none, 1 = even (total count of ones even), 2 = odd, and 3 = a constant 0 bit.
- R5: Mode bit 5 = 1 sends two stop bits and 0 sends one. Status bit 3 reads 1 while a frame is in progress.
- R6: A write to address 0 while a frame is in progress is ignored, and the frame in progress continues unchanged. The write sets sticky status bit 4.
- R7: When receive is enabled (mode bit 1), the receive buffer changes only when a whole character has been received. That event sets status bit 5 (buffer full), and a read of address 0 clears it.
- R8: With mode bit 2 = 0, a received character fills bits 0 to 6 of the buffer and bit 7 reads 0.
- R9: A received parity bit that does not match the mode's parity rule sets status bit 0.
- R10: A stop bit received low sets status bit 1.
- R11: A character that completes while status bit 5 is still set sets status bit 2, and the new character replaces the buffer.
- R12: A read of the status address clears status bits 0, 1, 2 and 4.
- R13: With divisor D written to address 3, one bit lasts 16*(D+1) clock cycles, and both directions use this bit time.
- R14: With mode bit 0 clear, a write to address 0 starts no frame. With mode bit 1 clear, line activity on `rxd` leaves the buffer and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read side effects take place at the clock edge that ends it |
| bus_addr | input | 2 | Register address: 0 data, 1 mode, 2 status, 3 divisor |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rxd | input | 1 | Serial receive line, asynchronous to `clk` |
| txd | output | 1 | Serial transmit line, idles high |

## Verification
A table of eight mode and data pairs drives both directions of the main function. The pairs cover 8-bit and 7-bit characters, all four parity codes and both stop counts. The data patterns are alternating bits, all zeros, all ones, and values whose top bit is set in 7-bit mode. Together they separate a wrong bit order, a dropped or extra data bit, a wrong parity rule and a failure to mask or zero-fill bit 7. Directed runs then cover the rest:
- a second write during a frame
- a buffer read in the middle of a frame
- two characters with no read between them
- a flipped parity bit and a low stop bit
- disabled directions
- a nonzero divisor, which shows whether the bit time scales with it

// File: rtl/uart_regport_pkg.sv
package uart_regport_pkg;

  localparam int CHAR_W = 8;

  // bus register map
  localparam logic [1:0] A_DATA   = 2'd0;
  localparam logic [1:0] A_MODE   = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;
  localparam logic [1:0] A_DIV    = 2'd3;

  // mode register bit positions
  localparam int M_TXEN  = 0;
  localparam int M_RXEN  = 1;
  localparam int M_LEN8  = 2;
  localparam int M_PARLO = 3;
  localparam int M_STOP2 = 5;
  localparam int MODE_W  = 6;

  // status register bit positions
  localparam int S_PERR  = 0;
  localparam int S_FERR  = 1;
  localparam int S_OVR   = 2;
  localparam int S_BUSY  = 3;
  localparam int S_WBUSY = 4;
  localparam int S_FULL  = 5;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_ZERO = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    FR_IDLE, FR_START, FR_DATA, FR_PAR, FR_STOP
  } frame_state_e;

  // parity bit that belongs after the character
  function automatic logic par_bit(input logic [CHAR_W-1:0] d,
                                   input logic len8,
                                   input par_mode_e pm);
    logic [CHAR_W-1:0] m;
    m = len8 ? d : {1'b0, d[CHAR_W-2:0]};
    case (pm)
      PAR_EVEN: par_bit = ^m;
      PAR_ODD:  par_bit = ~^m;
      default:  par_bit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick); // R13

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_regport_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [CHAR_W-1:0] data,
  input  logic              len8,
  input  par_mode_e         pmode,
  input  logic              stop2,
  output logic              busy,
  output logic              txd
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(CHAR_W);

  frame_state_e      st;
  logic [CW-1:0]     tcnt;
  logic [IW-1:0]     idx;
  logic [CHAR_W-1:0] hold;
  logic              len8_q, stop2_q, extra_stop, pbit;
  par_mode_e         pm_q;
  logic              bit_end;
  logic [IW-1:0]     nidx;
  logic [IW-1:0]     last_idx;

  assign busy     = (st != FR_IDLE);
  assign bit_end  = tick && (tcnt == CW'(OVS-1));
  assign nidx     = idx + 1'b1;
  assign last_idx = len8_q ? IW'(CHAR_W-1) : IW'(CHAR_W-2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= FR_IDLE;
      tcnt       <= '0;
      idx        <= '0;
      hold       <= '1;
      len8_q     <= 1'b1;
      stop2_q    <= 1'b0;
      extra_stop <= 1'b0;
      pbit       <= 1'b0;
      pm_q       <= PAR_NONE;
      txd        <= 1'b1;
    end else if (start && !busy) begin
      hold    <= data;
      len8_q  <= len8;
      stop2_q <= stop2;
      pm_q    <= pmode;
      pbit    <= par_bit(data, len8, pmode);
      tcnt    <= '0;
      st      <= FR_START;
      txd     <= 1'b0;
    end else if (busy && tick) begin
      tcnt <= tcnt + 1'b1;
      if (bit_end) begin
        case (st)
          FR_START: begin
            st  <= FR_DATA;
            idx <= '0;
            txd <= hold[0];
          end
          FR_DATA: begin
            if (idx == last_idx) begin
              if (pm_q != PAR_NONE) begin
                st  <= FR_PAR;
                txd <= pbit;
              end else begin
                st         <= FR_STOP;
                extra_stop <= stop2_q;
                txd        <= 1'b1;
              end
            end else begin
              idx <= nidx;
              txd <= hold[nidx];
            end
          end
          FR_PAR: begin
            st         <= FR_STOP;
            extra_stop <= stop2_q;
            txd        <= 1'b1;
          end
          FR_STOP: begin
            if (extra_stop) extra_stop <= 1'b0;
            else            st         <= FR_IDLE;
            txd <= 1'b1;
          end
          default: st <= FR_IDLE;
        endcase
      end
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R2
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R2
  AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_STOP) |-> txd); // R5

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_regport_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              rxd,
  input  logic              len8,
  input  par_mode_e         pmode,
  output logic              done,
  output logic [CHAR_W-1:0] char_out,
  output logic              perr,
  output logic              ferr
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(CHAR_W);

  frame_state_e      st;
  logic [1:0]        sync;
  logic              rxs;
  logic [CW-1:0]     tcnt;
  logic [IW-1:0]     idx;
  logic [CHAR_W-1:0] shreg;
  logic              par_rx;
  logic              mid_start, bit_ctr;
  logic [IW-1:0]     last_idx;

  assign rxs       = sync[1];
  assign mid_start = tick && (tcnt == CW'(OVS/2-1));
  assign bit_ctr   = tick && (tcnt == CW'(OVS-1));
  assign last_idx  = len8 ? IW'(CHAR_W-1) : IW'(CHAR_W-2);

  assign done     = (st == FR_STOP) && bit_ctr;
  assign char_out = len8 ? shreg : {1'b0, shreg[CHAR_W-2:0]};
  assign perr     = (pmode != PAR_NONE) && (par_rx != par_bit(shreg, len8, pmode));
  assign ferr     = !rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FR_IDLE;
      tcnt   <= '0;
      idx    <= '0;
      shreg  <= '0;
      par_rx <= 1'b0;
    end else begin
      case (st)
        FR_IDLE: begin
          tcnt <= '0;
          if (en && !rxs) st <= FR_START;
        end
        FR_START: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (mid_start) begin
            tcnt <= '0;
            idx  <= '0;
            st   <= rxs ? FR_IDLE : FR_DATA;
          end
        end
        FR_DATA: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (bit_ctr) begin
            shreg[idx] <= rxs;
            idx        <= idx + 1'b1;
            if (idx == last_idx) st <= (pmode != PAR_NONE) ? FR_PAR : FR_STOP;
          end
        end
        FR_PAR: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (bit_ctr) begin
            par_rx <= rxs;
            st     <= FR_STOP;
          end
        end
        FR_STOP: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (bit_ctr) st <= FR_IDLE;
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == FR_IDLE) && !en) |=> (st == FR_IDLE)); // R14

endmodule

// File: rtl/uart_regport.sv
module uart_regport
  import uart_regport_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int OVS    = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rxd,
  output logic              txd
);
  logic [MODE_W-1:0] mode;
  logic [DIV_W-1:0]  div;
  logic [CHAR_W-1:0] rx_buf;
  logic              rx_full, st_perr, st_ferr, st_ovr, st_wbusy;
  logic              tick, tx_busy, tx_start;
  logic              rx_done, rx_perr, rx_ferr;
  logic [CHAR_W-1:0] rx_char;
  logic              wr_data, rd_data, rd_stat, wr_div;
  par_mode_e         pmode;

  assign wr_data  = bus_wr && (bus_addr == A_DATA);
  assign wr_div   = bus_wr && (bus_addr == A_DIV);
  assign rd_data  = bus_rd && (bus_addr == A_DATA);
  assign rd_stat  = bus_rd && (bus_addr == A_STATUS);
  assign pmode    = par_mode_e'(mode[M_PARLO +: 2]);
  assign tx_start = wr_data && mode[M_TXEN] && !tx_busy;

  uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(div), .restart(wr_div), .tick(tick));

  uart_tx_frame #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start),
    .data(bus_wdata), .len8(mode[M_LEN8]), .pmode(pmode),
    .stop2(mode[M_STOP2]), .busy(tx_busy), .txd(txd));

  uart_rx_frame #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(mode[M_RXEN]), .rxd(rxd),
    .len8(mode[M_LEN8]), .pmode(pmode), .done(rx_done),
    .char_out(rx_char), .perr(rx_perr), .ferr(rx_ferr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      div  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MODE) mode <= bus_wdata[MODE_W-1:0];
      if (bus_addr == A_DIV)  div  <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf   <= '1;
      rx_full  <= 1'b0;
      st_perr  <= 1'b0;
      st_ferr  <= 1'b0;
      st_ovr   <= 1'b0;
      st_wbusy <= 1'b0;
    end else begin
      if (rd_data) rx_full <= 1'b0;
      if (rd_stat) begin
        st_perr  <= 1'b0;
        st_ferr  <= 1'b0;
        st_ovr   <= 1'b0;
        st_wbusy <= 1'b0;
      end
      if (wr_data && tx_busy) st_wbusy <= 1'b1;
      if (rx_done) begin
        rx_buf  <= rx_char;
        rx_full <= 1'b1;
        if (rx_perr) st_perr <= 1'b1;
        if (rx_ferr) st_ferr <= 1'b1;
        if (rx_full && !rd_data) st_ovr <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA:   bus_rdata = rx_buf;
      A_MODE:   bus_rdata = 8'(mode);
      A_STATUS: bus_rdata = {2'b00, rx_full, st_wbusy, tx_busy, st_ovr, st_ferr, st_perr};
      default:  bus_rdata = 8'(div);
    endcase
  end

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(rx_buf)); // R7
  AST_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !mode[M_LEN8]) |=> !rx_buf[7]); // R8
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !rd_data) |=> st_ovr); // R11
  AST_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_busy) |=> (st_wbusy && tx_busy)); // R6
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !rx_done && !wr_data) |=> !(st_perr || st_ferr || st_ovr || st_wbusy)); // R12

endmodule

// File: tb/tb_uart_regport.sv
module tb_uart_regport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       rxd = 1'b1;
  logic       txd;

  int total = 0;
  int bad = 0;
  int bp = 16;

  always #2 clk = ~clk;

  uart_regport dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd));

  // {mode, data}
  localparam logic [15:0] VEC [8] = '{
    16'h07A5, 16'h0700, 16'h0F37, 16'h17FF,
    16'h1F81, 16'h275A, 16'h03C3, 16'h0BFE};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [11:0] frame(input logic [7:0] m, input logic [7:0] d, output int nb);
    logic [11:0] f;
    int n, k;
    logic [7:0] md;
    logic p;
    f = '1; f[0] = 1'b0;
    n = m[2] ? 8 : 7;
    md = m[2] ? d : {1'b0, d[6:0]};
    for (int i = 0; i < n; i++) f[1+i] = md[i];
    k = 1 + n;
    if (m[4:3] != 2'd0) begin
      p = (m[4:3] == 2'd1) ? ^md : (m[4:3] == 2'd2) ? ~^md : 1'b0;
      f[k] = p; k++;
    end
    nb = k + (m[5] ? 2 : 1);
    return f;
  endfunction

  task automatic tx_capture(output logic [11:0] got, input int nb);
    got = '1;
    while (txd !== 1'b0) @(negedge clk);
    repeat (bp/2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      got[i] = txd;
      if (i < nb-1) repeat (bp) @(negedge clk);
    end
  endtask

  task automatic rx_drive(input logic [7:0] m, input logic [7:0] d, input bit flip, input bit badstop);
    logic [11:0] f;
    int nb, ps;
    f = frame(m, d, nb);
    ps = (m[2] ? 9 : 8);
    if (flip && m[4:3] != 2'd0) f[ps] = ~f[ps];
    if (badstop) f[ps + (m[4:3] != 2'd0 ? 1 : 0)] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (bp-1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (2*bp) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, last_rx;
    logic [11:0] got, exp;
    int nb, lowcnt;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd idle", 32'(txd), 32'h1);
    rd(2'd0, r); chk("R1 data reset", 32'(r), 32'hFF);
    rd(2'd2, r); chk("R1 status reset", 32'(r), 32'h00);
    rd(2'd1, r); chk("R1 mode reset", 32'(r), 32'h00);

    // table: R2 R3 R4 R5 transmit, R7 R8 receive
    for (int v = 0; v < 8; v++) begin
      logic [7:0] m, d, em;
      m = VEC[v][15:8]; d = VEC[v][7:0];
      em = m[2] ? d : {1'b0, d[6:0]};
      wr(2'd1, m);
      exp = frame(m, d, nb);
      wr(2'd0, d);
      tx_capture(got, nb);
      chk($sformatf("R2 R3 R4 R5 tx frame vec%0d", v), 32'(got), 32'(exp));
      rx_drive(m, d, 1'b0, 1'b0);
      rd(2'd2, r); chk($sformatf("R7 full flag vec%0d", v), 32'(r), 32'h20);
      rd(2'd0, r); chk($sformatf("R7 R8 rx data vec%0d", v), 32'(r), 32'(em));
      last_rx = em;
      rd(2'd2, r); chk($sformatf("R7 full cleared vec%0d", v), 32'(r), 32'h00);
    end

    // R5 busy at centre of the bit after the first stop
    wr(2'd1, 8'h07); wr(2'd0, 8'h55);
    repeat (bp/2 + 10*bp) @(negedge clk);
    rd(2'd2, r); chk("R5 one stop idle", 32'(r[3]), 32'h0);
    repeat (2*bp) @(negedge clk);
    wr(2'd1, 8'h27); wr(2'd0, 8'h55);
    repeat (bp/2 + 10*bp) @(negedge clk);
    rd(2'd2, r); chk("R5 two stop busy", 32'(r[3]), 32'h1);
    repeat (2*bp) @(negedge clk);

    // R6 write during frame
    wr(2'd1, 8'h07);
    exp = frame(8'h07, 8'h3C, nb);
    fork
      begin wr(2'd0, 8'h3C); tx_capture(got, nb); end
      begin repeat (40) @(negedge clk); wr(2'd0, 8'hFF); end
    join
    chk("R6 frame unchanged", 32'(got), 32'(exp));
    rd(2'd2, r); chk("R6 busy write flag", 32'(r & 8'h10), 32'h10);
    rd(2'd2, r); chk("R12 flag cleared", 32'(r & 8'h10), 32'h0);
    repeat (2*bp) @(negedge clk);

    // R7 buffer stable mid-frame
    fork
      rx_drive(8'h07, 8'h96, 1'b0, 1'b0);
      begin repeat (5*bp) @(negedge clk); rd(2'd0, r); end
    join
    chk("R7 buffer holds mid frame", 32'(r), 32'(last_rx));
    rd(2'd0, r); chk("R7 new char", 32'(r), 32'h96);

    // R11 overrun
    rx_drive(8'h07, 8'h11, 1'b0, 1'b0);
    rx_drive(8'h07, 8'h22, 1'b0, 1'b0);
    rd(2'd2, r); chk("R11 overrun flag", 32'(r & 8'h04), 32'h04);
    rd(2'd0, r); chk("R11 newest char kept", 32'(r), 32'h22);

    // R9 parity error, R12 clear
    wr(2'd1, 8'h0F);
    rx_drive(8'h0F, 8'h37, 1'b1, 1'b0);
    rd(2'd2, r); chk("R9 parity error", 32'(r & 8'h01), 32'h01);
    rd(2'd2, r); chk("R12 parity cleared", 32'(r & 8'h07), 32'h0);
    rd(2'd0, r);

    // R10 framing error
    wr(2'd1, 8'h07);
    rx_drive(8'h07, 8'h44, 1'b0, 1'b1);
    rd(2'd2, r); chk("R10 framing error", 32'(r & 8'h02), 32'h02);
    rd(2'd0, r);

    // R14 transmit disabled
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    lowcnt = 0;
    for (int i = 0; i < 12*bp; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lowcnt++;
    end
    chk("R14 tx disabled line high", 32'(lowcnt), 32'h0);
    rd(2'd2, r); chk("R14 tx disabled not busy", 32'(r), 32'h00);
    // R14 receive disabled
    rx_drive(8'h07, 8'h5A, 1'b0, 1'b0);
    rd(2'd2, r); chk("R14 rx disabled status", 32'(r), 32'h00);
    rd(2'd0, r); chk("R14 rx disabled buffer", 32'(r), 32'h44);

    // R13 divisor 3
    wr(2'd3, 8'd3); bp = 64;
    wr(2'd1, 8'h07); wr(2'd0, 8'hC7);
    while (txd !== 1'b0) @(negedge clk);
    lowcnt = 0;
    while (txd === 1'b0) begin lowcnt++; @(negedge clk); end
    chk("R13 start bit length", 32'(lowcnt >= 61 && lowcnt <= 65), 32'h1);
    repeat (12*bp) @(negedge clk);
    exp = frame(8'h07, 8'hA9, nb);
    wr(2'd0, 8'hA9);
    tx_capture(got, nb);
    chk("R13 tx frame at divisor 3", 32'(got), 32'(exp));
    repeat (2*bp) @(negedge clk);
    rx_drive(8'h07, 8'h3D, 1'b0, 1'b0);
    rd(2'd0, r); chk("R13 rx at divisor 3", 32'(r), 32'h3D);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule